// File: doc/BRIEF.md
# Packet Header Interpreter

This block sits on the receive side of one serial link channel and watches the character stream that the link codec delivers. Each character is either a data byte or an end marker, and an end marker is either a normal end-of-packet or an error end. In protocol mode the block treats the first four data bytes after each end marker as a packet header. It checks that header and then does one of three things: it forwards the payload to the receive FIFO, it issues an execution request to the command unit, or it raises an error. Every header byte is also copied to the acknowledge path, tagged with its position.

In transparent mode the block does no interpretation. Every character is copied to the FIFO output, including the end markers. Wormhole routing runs in this mode, so the router further downstream sees the raw first byte. All outputs are registered, and each one reflects the character accepted on the previous clock edge.

Header layout: byte 0 holds the destination address and byte 1 the command code. Bytes 2 and 3 form a 16-bit argument, and byte 2 is the upper half.

Top module: `hdr_interp`

## Requirements
- R1: After reset, and after any cycle spent in transparent mode, protocol mode discards every character until an end marker arrives. A stream picked up mid-packet produces no output.
- R2: In protocol mode the four data characters that follow an end marker are header bytes. Each one appears on the acknowledge output one cycle after it is accepted, with its position 0 to 3 on `ack_idx`.
- R3: If header byte 0 differs from `node_addr`, `err_code` becomes 1 (address error) and the rest of the packet is discarded. The address check wins over every command check.
- R4: Command code 0x01 selects data transfer. Every later payload character, including the terminating end marker, appears on the FIFO output one cycle after it is accepted.
- R5: Command codes 0x10 to 0x17 are simple control commands. They produce a one-cycle `cmd_req` together with `cmd_code` and `cmd_arg` = {byte 2, byte 3}, and the payload is discarded.
- R6: Command codes 0x18 to 0x1F are safety-critical. They produce `cmd_req` only when `safe_armed` is high as the last header byte is accepted. Otherwise `err_code` becomes 3 (safety error) and no request is made.
- R7: Any other command code sets `err_code` to 2 (unknown command) and discards the packet.
- R8: An end marker that arrives after one to three header bytes sets `err_code` to 4 (short header). An end marker that arrives with no header bytes (an empty packet) has no effect.
- R9: `err_pulse` is high for exactly one cycle per error. `err_code` keeps its value until the first header byte of the next packet is accepted, and it reads 0 from that point on.
- R10: When `proto_mode` is low, every character appears unchanged on the FIFO output one cycle later. In that mode the acknowledge, command and error outputs stay idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_valid | input | 1 | A character is presented this cycle |
| ch_ctrl | input | 1 | 1: end marker, 0: data byte |
| ch_data | input | 8 | Data byte; for an end marker bit 0 is 0 for a normal end and 1 for an error end |
| node_addr | input | 8 | Address assigned to this channel |
| proto_mode | input | 1 | 1: protocol mode, 0: transparent mode |
| safe_armed | input | 1 | Safety-critical commands are enabled |
| fifo_valid | output | 1 | A character is written to the receive FIFO |
| fifo_ctrl | output | 1 | The FIFO character is an end marker |
| fifo_data | output | 8 | The FIFO character |
| ack_valid | output | 1 | A header byte is offered to the acknowledge generator |
| ack_idx | output | 2 | Position of that header byte |
| ack_data | output | 8 | The header byte |
| cmd_req | output | 1 | One-cycle execution request |
| cmd_code | output | 8 | Command code of the request |
| cmd_arg | output | 16 | Argument of the request |
| err_pulse | output | 1 | One-cycle error strobe |
| err_code | output | 3 | Held error cause: 0 none, 1 address, 2 command, 3 safety, 4 short |

## Verification
Some properties are checked on every cycle by the assertions. An error strobe never lasts two cycles, and it always comes with a nonzero cause. A request for a safety-critical code is only made when arming was present on the previous edge. While the previous cycle was transparent, the acknowledge, command and error outputs stay quiet. Other behaviour can only be shown by the bench's scenarios, because it depends on a stream's history: discarding a packet that was picked up mid-way, the priority of the address check over the command class, the difference between an empty packet and a short one, and how long the error cause is held.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
  localparam int HDR_LEN = 4;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_ADDR  = 3'd1;
  localparam logic [2:0] ERR_CMD   = 3'd2;
  localparam logic [2:0] ERR_SAFE  = 3'd3;
  localparam logic [2:0] ERR_SHORT = 3'd4;

  typedef enum logic [1:0] {ST_SYNC, ST_HDR, ST_PAY, ST_DROP} rx_state_t;
  typedef enum logic [1:0] {CC_DATA, CC_SIMPLE, CC_CRIT, CC_BAD} cmd_class_t;

  // Command code groups: 0x01 data, 0x10-0x17 simple, 0x18-0x1F safety-critical
  function automatic cmd_class_t classify(input logic [7:0] code);
    if (code == 8'h01)              return CC_DATA;
    else if (code[7:3] == 5'b00010) return CC_SIMPLE;
    else if (code[7:3] == 5'b00011) return CC_CRIT;
    else                            return CC_BAD;
  endfunction
endpackage

// File: rtl/hdr_capture.sv
module hdr_capture #(
  parameter int DW = 8,
  localparam int HL = hdr_pkg::HDR_LEN,
  localparam int IDX_W = $clog2(HL)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       take,
  input  logic [DW-1:0]              byte_in,
  output logic [IDX_W-1:0]           idx,
  output logic [HL-2:0][DW-1:0]      slots
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       idx <= '0;
    else if (clr)                     idx <= '0;
    else if (take)                    idx <= (idx == IDX_W'(HL-1)) ? '0 : idx + 1'b1;
  end

  for (genvar g = 0; g < HL-1; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              slots[g] <= '0;
      else if (take && idx == IDX_W'(g))       slots[g] <= byte_in;
    end
  end
endmodule

// File: rtl/hdr_judge.sv
module hdr_judge #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] cmd,
  input  logic [DW-1:0] node_addr,
  input  logic          armed,
  output logic          go_payload,
  output logic          go_exec,
  output logic [2:0]    verdict_err
);
  import hdr_pkg::*;
  cmd_class_t cls;

  always_comb begin
    cls         = classify(cmd[7:0]);
    go_payload  = 1'b0;
    go_exec     = 1'b0;
    verdict_err = ERR_NONE;
    if (addr != node_addr) verdict_err = ERR_ADDR;
    else begin
      case (cls)
        CC_DATA:   go_payload = 1'b1;
        CC_SIMPLE: go_exec    = 1'b1;
        CC_CRIT:   if (armed) go_exec = 1'b1; else verdict_err = ERR_SAFE;
        default:   verdict_err = ERR_CMD;
      endcase
    end
  end

  // R3 R5 R6 R7: exactly one outcome per header
  always_comb begin
    outcome_onehot_chk: assert ($onehot({go_payload, go_exec, verdict_err != ERR_NONE}));
  end
endmodule

// File: rtl/hdr_interp.sv
module hdr_interp #(
  parameter int DW = 8,
  localparam int HL = hdr_pkg::HDR_LEN,
  localparam int IDX_W = $clog2(HL),
  localparam int ARG_W = 2*DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_valid,
  input  logic             ch_ctrl,
  input  logic [DW-1:0]    ch_data,
  input  logic [DW-1:0]    node_addr,
  input  logic             proto_mode,
  input  logic             safe_armed,
  output logic             fifo_valid,
  output logic             fifo_ctrl,
  output logic [DW-1:0]    fifo_data,
  output logic             ack_valid,
  output logic [IDX_W-1:0] ack_idx,
  output logic [DW-1:0]    ack_data,
  output logic             cmd_req,
  output logic [DW-1:0]    cmd_code,
  output logic [ARG_W-1:0] cmd_arg,
  output logic             err_pulse,
  output logic [2:0]       err_code
);
  import hdr_pkg::*;

  rx_state_t               st;
  logic [IDX_W-1:0]        idx;
  logic [HL-2:0][DW-1:0]   slots;
  logic                    hdr_take, hdr_last, end_seen, cap_clr;
  logic                    go_payload, go_exec;
  logic [2:0]              verdict_err;

  assign end_seen = ch_valid && ch_ctrl;
  assign hdr_take = ch_valid && proto_mode && (st == ST_HDR) && !ch_ctrl;
  assign hdr_last = hdr_take && (idx == IDX_W'(HL-1));
  assign cap_clr  = !proto_mode || (st != ST_HDR) || end_seen;

  hdr_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr(cap_clr), .take(hdr_take),
    .byte_in(ch_data), .idx(idx), .slots(slots)
  );

  hdr_judge #(.DW(DW)) u_judge (
    .addr(slots[0]), .cmd(slots[1]), .node_addr(node_addr), .armed(safe_armed),
    .go_payload(go_payload), .go_exec(go_exec), .verdict_err(verdict_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_SYNC;
      fifo_valid <= 1'b0; fifo_ctrl <= 1'b0; fifo_data <= '0;
      ack_valid <= 1'b0; ack_idx <= '0; ack_data <= '0;
      cmd_req <= 1'b0; cmd_code <= '0; cmd_arg <= '0;
      err_pulse <= 1'b0; err_code <= ERR_NONE;
    end else begin
      fifo_valid <= 1'b0;
      ack_valid  <= 1'b0;
      cmd_req    <= 1'b0;
      err_pulse  <= 1'b0;
      if (!proto_mode) begin
        st <= ST_SYNC;
        if (ch_valid) begin
          fifo_valid <= 1'b1; fifo_ctrl <= ch_ctrl; fifo_data <= ch_data;
        end
      end else if (ch_valid) begin
        case (st)
          ST_SYNC: if (ch_ctrl) st <= ST_HDR;
          ST_HDR: begin
            if (ch_ctrl) begin
              if (idx != '0) begin
                err_pulse <= 1'b1; err_code <= ERR_SHORT;
              end
            end else begin
              ack_valid <= 1'b1; ack_idx <= idx; ack_data <= ch_data;
              if (idx == '0) err_code <= ERR_NONE;
              if (hdr_last) begin
                if (go_payload) st <= ST_PAY;
                else begin
                  st <= ST_DROP;
                  if (go_exec) begin
                    cmd_req <= 1'b1; cmd_code <= slots[1]; cmd_arg <= {slots[2], ch_data};
                  end else begin
                    err_pulse <= 1'b1; err_code <= verdict_err;
                  end
                end
              end
            end
          end
          ST_PAY: begin
            fifo_valid <= 1'b1; fifo_ctrl <= ch_ctrl; fifo_data <= ch_data;
            if (ch_ctrl) st <= ST_HDR;
          end
          default: if (ch_ctrl) st <= ST_HDR;
        endcase
      end
    end
  end

  // R9
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);
  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_code != ERR_NONE);
  // R6
  crit_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && classify(cmd_code[7:0]) == CC_CRIT) |-> $past(safe_armed));
  // R5
  cmd_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> (classify(cmd_code[7:0]) inside {CC_SIMPLE, CC_CRIT}));
  // R10
  transp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!proto_mode) |-> (!ack_valid && !cmd_req && !err_pulse));
  // R3 R7
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_pulse && (cmd_req || fifo_valid)));
endmodule

// File: tb/hdr_interp_tb.sv
module hdr_interp_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ch_valid = 1'b0, ch_ctrl = 1'b0;
  logic [7:0] ch_data = '0;
  logic [7:0] node_addr = 8'h5A;
  logic proto_mode = 1'b1, safe_armed = 1'b0;
  logic fifo_valid, fifo_ctrl, ack_valid, cmd_req, err_pulse;
  logic [7:0] fifo_data, ack_data, cmd_code;
  logic [1:0] ack_idx;
  logic [15:0] cmd_arg;
  logic [2:0] err_code;

  always #2 clk = ~clk;

  hdr_interp u_dut (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_ctrl(ch_ctrl), .ch_data(ch_data),
    .node_addr(node_addr), .proto_mode(proto_mode), .safe_armed(safe_armed),
    .fifo_valid(fifo_valid), .fifo_ctrl(fifo_ctrl), .fifo_data(fifo_data),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .ack_data(ack_data),
    .cmd_req(cmd_req), .cmd_code(cmd_code), .cmd_arg(cmd_arg),
    .err_pulse(err_pulse), .err_code(err_code)
  );

  int checks = 0, fails = 0;
  logic [8:0]  q_fifo[$];
  logic [9:0]  q_ack[$];
  logic [23:0] q_cmd[$];
  logic [2:0]  q_err[$];

  int m_st = 0, m_idx = 0;
  logic [7:0] m_b [4];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model, written from the requirements
  task automatic model(input bit c, input logic [7:0] d);
    if (!proto_mode) begin
      q_fifo.push_back({c, d}); m_st = 0;
    end else case (m_st)
      0: if (c) begin m_st = 1; m_idx = 0; end
      1: if (c) begin
           if (m_idx != 0) q_err.push_back(3'd4);
           m_idx = 0;
         end else begin
           q_ack.push_back({2'(m_idx), d});
           m_b[m_idx] = d;
           if (m_idx == 3) begin
             m_idx = 0; m_st = 3;
             if (m_b[0] != node_addr) q_err.push_back(3'd1);
             else if (m_b[1] == 8'h01) m_st = 2;
             else if (m_b[1] >= 8'h10 && m_b[1] <= 8'h17) q_cmd.push_back({m_b[1], m_b[2], m_b[3]});
             else if (m_b[1] >= 8'h18 && m_b[1] <= 8'h1F) begin
               if (safe_armed) q_cmd.push_back({m_b[1], m_b[2], m_b[3]});
               else q_err.push_back(3'd3);
             end else q_err.push_back(3'd2);
           end else m_idx++;
         end
      2: begin q_fifo.push_back({c, d}); if (c) begin m_st = 1; m_idx = 0; end end
      default: if (c) begin m_st = 1; m_idx = 0; end
    endcase
  endtask

  task automatic send(input bit c, input logic [7:0] d);
    @(negedge clk);
    ch_valid = 1'b1; ch_ctrl = c; ch_data = d;
    model(c, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ch_valid = 1'b0;
    end
  endtask

  task automatic set_mode(input bit v);
    idle(1); proto_mode = v; if (!v) m_st = 0;
  endtask

  task automatic set_armed(input bit v);
    idle(1); safe_armed = v;
  endtask

  task automatic packet(input logic [7:0] a, input logic [7:0] cmd,
                        input logic [7:0] b2, input logic [7:0] b3,
                        input int npay, input bit err_end);
    send(0, a); send(0, cmd); send(0, b2); send(0, b3);
    for (int i = 0; i < npay; i++) send(0, 8'hA0 + 8'(i));
    send(1, {7'd0, err_end});
  endtask

  // monitor: pops expected items as outputs appear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (fifo_valid) begin
          if (q_fifo.size() == 0) check(0, "R1/R4/R10", "unexpected fifo char", {fifo_ctrl, fifo_data}, 0);
          else begin
            logic [8:0] e; e = q_fifo.pop_front();
            check({fifo_ctrl, fifo_data} == e, "R4/R10", "fifo char", {fifo_ctrl, fifo_data}, e);
          end
        end
        if (ack_valid) begin
          if (q_ack.size() == 0) check(0, "R1/R2", "unexpected ack", {ack_idx, ack_data}, 0);
          else begin
            logic [9:0] e; e = q_ack.pop_front();
            check({ack_idx, ack_data} == e, "R2", "ack byte", {ack_idx, ack_data}, e);
            if (ack_idx == 2'd0) check(err_code == 3'd0, "R9", "cause cleared at header", err_code, 0);
          end
        end
        if (cmd_req) begin
          if (q_cmd.size() == 0) check(0, "R5/R6", "unexpected request", {cmd_code, cmd_arg}, 0);
          else begin
            logic [23:0] e; e = q_cmd.pop_front();
            check({cmd_code, cmd_arg} == e, "R5/R6", "request", {cmd_code, cmd_arg}, e);
          end
        end
        if (err_pulse) begin
          if (q_err.size() == 0) check(0, "R3/R6/R7/R8", "unexpected error", err_code, 0);
          else begin
            logic [2:0] e; e = q_err.pop_front();
            check(err_code == e, "R3/R6/R7/R8", "error cause", err_code, e);
          end
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!fifo_valid && !ack_valid && !cmd_req && !err_pulse, "R1", "reset outputs idle",
          {fifo_valid, ack_valid, cmd_req, err_pulse}, 0);
    check(err_code == 3'd0, "R9", "reset cause", err_code, 0);
    rst_n = 1'b1;
    idle(2);
    // R1: mid-packet bytes discarded until the first end marker
    send(0, 8'h5A); send(0, 8'h01); send(0, 8'h11); send(0, 8'h22); send(0, 8'h33);
    send(1, 8'h00);
    // R2 R4: data packet, payload forwarded with its end marker
    packet(8'h5A, 8'h01, 8'h00, 8'h03, 3, 0);
    // R3: wrong address, even with a data command
    packet(8'h5B, 8'h01, 8'h00, 8'h02, 2, 0);
    idle(3);
    check(err_code == 3'd1, "R3", "address cause held", err_code, 1);
    // R7: unknown command
    packet(8'h5A, 8'h55, 8'h12, 8'h34, 1, 1);
    // R5: simple control command with argument
    packet(8'h5A, 8'h13, 8'hBE, 8'hEF, 2, 0);
    // R6: safety-critical, disarmed then armed
    packet(8'h5A, 8'h1A, 8'h01, 8'h02, 0, 0);
    idle(2);
    check(err_code == 3'd3, "R6", "safety cause held", err_code, 3);
    set_armed(1);
    packet(8'h5A, 8'h1F, 8'h77, 8'h88, 1, 0);
    set_armed(0);
    // R3: address check has priority over a bad command
    packet(8'h00, 8'h99, 8'h00, 8'h00, 0, 0);
    // R8: short header ended by an error end, then an empty packet
    send(0, 8'h5A); send(0, 8'h01); send(1, 8'h01);
    idle(4);
    check(err_code == 3'd4, "R9", "short cause held over idle", err_code, 4);
    send(1, 8'h00);
    idle(2);
    check(err_code == 3'd4, "R8", "empty packet leaves cause", err_code, 4);
    packet(8'h5A, 8'h01, 8'h00, 8'h01, 1, 0);
    // R10: transparent mode copies everything
    set_mode(0);
    packet(8'h5A, 8'h13, 8'h01, 8'h02, 2, 1);
    send(0, 8'hC3);
    // R1: back to protocol, mid-stream bytes discarded
    set_mode(1);
    send(0, 8'h5A); send(0, 8'h01); send(0, 8'h00); send(0, 8'h00); send(0, 8'hEE);
    send(1, 8'h00);
    packet(8'h5A, 8'h10, 8'h00, 8'h00, 0, 0);
    idle(6);
    check(q_fifo.size() == 0, "R4", "fifo items pending", q_fifo.size(), 0);
    check(q_ack.size() == 0, "R2", "ack items pending", q_ack.size(), 0);
    check(q_cmd.size() == 0, "R5", "requests pending", q_cmd.size(), 0);
    check(q_err.size() == 0, "R8", "errors pending", q_err.size(), 0);
    summary();
  end
endmodule